// File: doc/BRIEF.md
# Serial Latched Quad Output Controller

This block holds the control logic for four low-side output switches. A host writes the switch states over a three-wire serial link made of a serial clock, a data line and a latch strobe. Bits move into a four-bit holding chain. A rising latch edge then copies the chain into the output word that drives the switches. The tail of the holding chain is the serial output. Several controllers can therefore be chained, and one latch edge updates all of them together.

While the latch strobe is high, serial clock edges do not shift. Each such edge instead loads the four digital fault flags into the holding chain. The next shift sequence then carries the fault status out through the serial output. An active-low enable forces all four drives off without disturbing the stored output word.

Every serial input is sampled by the system clock through a two-flop synchronizer. Rising edges are found in the system clock domain. Reset is synchronous and active-high.

Top module: `qsw_serial_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until new data is latched, drive_o is 4'b0000 and ser_dout_o is 0.
- R2: Each rising edge of ser_clk_i seen while latch_i is low shifts ser_din_i into the holding chain. ser_dout_o shows the bit that entered four serial clock edges earlier.
- R3: Channel order: the first of four shifted bits lands in drive_o[3] (channel 4) and the last lands in drive_o[0] (channel 1). A 1 turns a switch on.
- R4: drive_o changes only after a rising edge of latch_i. Shifting alone leaves it unchanged.
- R5: A rising ser_clk_i edge seen while latch_i is high does not shift. It loads fault_i into the holding chain, with fault_i[k] in the chain position of channel k+1. fault_i[3] then appears first on ser_dout_o.
- R6: While out_en_n_i is 1, drive_o is 4'b0000. When out_en_n_i returns to 0, the latched word reappears without a new latch edge.
- R7: When a latch rising edge and a serial clock rising edge are seen in the same system cycle, the output word takes the holding contents from before that edge, and the holding chain takes the fault flags.
- R8: When ser_dout_o of one device feeds ser_din_i of a second device that shares its clock and latch, eight serial clocks place the first four bits in the second device and the last four in the first device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to clk |
| ser_din_i | input | 1 | Serial data in |
| latch_i | input | 1 | Latch strobe; a rising edge updates the outputs, a high level selects fault load |
| out_en_n_i | input | 1 | Active-low output enable |
| fault_i | input | NCH | Fault flags, bit k for channel k+1 |
| ser_dout_o | output | 1 | Tail of the holding chain |
| drive_o | output | NCH | Switch drive bits, 1 = on |

## Verification
Two functions can fall in the same system cycle: the latch copy into the output word and the fault load into the holding chain. This happens when the latch strobe and the serial clock rise together. The bench provokes it by raising both inputs at the same instant, so both synchronizers report their edges in the same cycle. It judges the result from two sides. The drive outputs must show the shifted pattern from before the edge, and the serial output must show the fault flag of channel 4. A two-device chain runs throughout, so both devices are judged together for every pattern.

// File: rtl/qsw_pkg.sv
package qsw_pkg;
  localparam int unsigned QSW_NCH_DEF  = 4;
  localparam int unsigned QSW_SYNC_DEF = 2;

  // what the holding chain does in a given system cycle
  typedef enum logic [1:0] {
    HOLD_IDLE  = 2'd0,
    HOLD_SHIFT = 2'd1,
    HOLD_LOAD  = 2'd2
  } hold_op_e;
endpackage

// File: rtl/qsw_sync.sv
module qsw_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qsw_rise.sv
module qsw_rise (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/qsw_holding.sv
module qsw_holding
  import qsw_pkg::*;
#(
  parameter int unsigned NCH = QSW_NCH_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  hold_op_e       op,
  input  logic           din,
  input  logic [NCH-1:0] par,
  output logic [NCH-1:0] chain
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      unique case (op)
        HOLD_SHIFT: chain <= {chain[NCH-2:0], din};
        HOLD_LOAD:  chain <= par;
        default:    chain <= chain;
      endcase
    end
  end
endmodule

// File: rtl/qsw_outstage.sv
module qsw_outstage #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           take,
  input  logic [NCH-1:0] src,
  input  logic           off,
  output logic [NCH-1:0] word,
  output logic [NCH-1:0] drive
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      drive <= '0;
    end else begin
      if (take) word <= src;
      drive <= off ? '0 : word;
    end
  end
endmodule

// File: rtl/qsw_serial_ctrl.sv
module qsw_serial_ctrl
  import qsw_pkg::*;
#(
  parameter int unsigned NCH         = QSW_NCH_DEF,
  parameter int unsigned SYNC_STAGES = QSW_SYNC_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_clk_i,
  input  logic           ser_din_i,
  input  logic           latch_i,
  input  logic           out_en_n_i,
  input  logic [NCH-1:0] fault_i,
  output logic           ser_dout_o,
  output logic [NCH-1:0] drive_o
);
  localparam int unsigned NSTROBE = 2;   // index 0: serial clock, 1: latch

  logic [NSTROBE-1:0] strobe_raw, strobe_lvl, strobe_rise;
  logic               din_s;
  logic               en_off;
  logic [NCH-1:0]     fault_s;
  logic [NCH-1:0]     hold_q;
  logic [NCH-1:0]     out_word;
  hold_op_e           hold_op;
  logic               sclk_rise, latch_lvl, latch_rise;

  assign strobe_raw = {latch_i, ser_clk_i};

  qsw_sync #(.W(NSTROBE), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_strobe (
    .clk(clk), .rst(rst), .d(strobe_raw), .q(strobe_lvl));

  qsw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
    .clk(clk), .rst(rst), .d(ser_din_i), .q(din_s));

  qsw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
    .clk(clk), .rst(rst), .d(out_en_n_i), .q(en_off));

  qsw_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_fault (
    .clk(clk), .rst(rst), .d(fault_i), .q(fault_s));

  for (genvar g = 0; g < NSTROBE; g++) begin : g_edge
    qsw_rise u_rise (
      .clk(clk), .rst(rst), .lvl(strobe_lvl[g]), .rise(strobe_rise[g]));
  end

  assign sclk_rise  = strobe_rise[0];
  assign latch_lvl  = strobe_lvl[1];
  assign latch_rise = strobe_rise[1];

  always_comb begin
    if (!sclk_rise)    hold_op = HOLD_IDLE;
    else if (latch_lvl) hold_op = HOLD_LOAD;
    else               hold_op = HOLD_SHIFT;
  end

  qsw_holding #(.NCH(NCH)) u_hold (
    .clk(clk), .rst(rst), .op(hold_op), .din(din_s), .par(fault_s),
    .chain(hold_q));

  qsw_outstage #(.NCH(NCH)) u_out (
    .clk(clk), .rst(rst), .take(latch_rise), .src(hold_q), .off(en_off),
    .word(out_word), .drive(drive_o));

  assign ser_dout_o = hold_q[NCH-1];
endmodule

// File: rtl/qsw_serial_ctrl_chk.sv
module qsw_serial_ctrl_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           sclk_rise,
  input logic           latch_lvl,
  input logic           latch_rise,
  input logic           din_s,
  input logic           en_off,
  input logic [NCH-1:0] fault_s,
  input logic [NCH-1:0] hold_q,
  input logic [NCH-1:0] out_word,
  input logic [NCH-1:0] drive_o,
  input logic           ser_dout_o
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (drive_o == '0 && ser_dout_o == 1'b0));

  // R2
  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !latch_lvl) |=>
      (hold_q == {$past(hold_q[NCH-2:0]), $past(din_s)}));

  // R4
  a_r4_word_holds: assert property (@(posedge clk) disable iff (rst)
    !latch_rise |=> $stable(out_word));

  // R5
  a_r5_fault_load: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && latch_lvl) |=> (hold_q == $past(fault_s)));

  // R5: with no serial clock edge the chain keeps its contents
  a_r5_chain_idle: assert property (@(posedge clk) disable iff (rst)
    !sclk_rise |=> $stable(hold_q));

  // R6
  a_r6_enable_off: assert property (@(posedge clk) disable iff (rst)
    en_off |=> (drive_o == '0));

  // R7
  a_r7_latch_copy: assert property (@(posedge clk) disable iff (rst)
    latch_rise |=> (out_word == $past(hold_q)));
endmodule

bind qsw_serial_ctrl qsw_serial_ctrl_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .latch_lvl(latch_lvl),
  .latch_rise(latch_rise), .din_s(din_s), .en_off(en_off),
  .fault_s(fault_s), .hold_q(hold_q), .out_word(out_word),
  .drive_o(drive_o), .ser_dout_o(ser_dout_o));

// File: tb/qsw_serial_ctrl_tb_top.sv
module qsw_serial_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int WDOG_LIMIT = 100000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           sclk = 1'b0, din = 1'b0, latch = 1'b0, en_n = 1'b0;
  logic [NCH-1:0] fault1 = '0, fault2 = '0;
  logic           dout1, dout2;
  logic [NCH-1:0] drv1, drv2;

  always #(CLK_PERIOD/2) clk = ~clk;

  qsw_serial_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_din_i(din), .latch_i(latch),
    .out_en_n_i(en_n), .fault_i(fault1), .ser_dout_o(dout1), .drive_o(drv1));

  qsw_serial_ctrl #(.NCH(NCH)) dut2_i (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_din_i(dout1), .latch_i(latch),
    .out_en_n_i(en_n), .fault_i(fault2), .ser_dout_o(dout2), .drive_o(drv2));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int             due;
    logic [NCH-1:0] d1;
    logic           o1;
    logic [NCH-1:0] d2;
    logic           o2;
    string          tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;

  // reference state, kept from the requirements
  logic [NCH-1:0] m_sr1 = '0, m_sr2 = '0, m_out1 = '0, m_out2 = '0;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.d1  = en_n ? '0 : m_out1;
    e.o1  = m_sr1[NCH-1];
    e.d2  = en_n ? '0 : m_out2;
    e.o2  = m_sr2[NCH-1];
    e.tag = tag;
    exp_q.push_back(e);
    idle(2);
  endtask

  task automatic serial_edge();
    if (latch) begin
      m_sr1 = fault1;
      m_sr2 = fault2;
    end else begin
      m_sr2 = {m_sr2[NCH-2:0], m_sr1[NCH-1]};
      m_sr1 = {m_sr1[NCH-2:0], din};
    end
  endtask

  task automatic shift_bit(input logic b);
    din = b;
    idle(3);
    sclk = 1'b1;
    serial_edge();
    idle(5);
    sclk = 1'b0;
    idle(4);
  endtask

  task automatic strobe_latch();
    latch  = 1'b1;
    m_out1 = m_sr1;
    m_out2 = m_sr2;
    idle(6);
    latch = 1'b0;
    idle(4);
  endtask

  task automatic load_faults();
    latch  = 1'b1;
    m_out1 = m_sr1;
    m_out2 = m_sr2;
    idle(5);
    sclk = 1'b1;
    serial_edge();
    idle(5);
    sclk = 1'b0;
    idle(4);
    latch = 1'b0;
    idle(4);
  endtask

  // monitor: pops expectations when they fall due and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      cur = exp_q.pop_front();
      checks++;
      if (drv1 !== cur.d1 || dout1 !== cur.o1 ||
          drv2 !== cur.d2 || dout2 !== cur.o2) begin
        errors++;
        $display("FAIL %s: got drv1=%b dout1=%b drv2=%b dout2=%b expected drv1=%b dout1=%b drv2=%b dout2=%b",
                 cur.tag, drv1, dout1, drv2, dout2, cur.d1, cur.o1, cur.d2, cur.o2);
      end
    end
  end

  initial begin
    wait (cyc > WDOG_LIMIT);
    errors++;
    $display("FAIL watchdog: got cycle %0d expected end before %0d", cyc, WDOG_LIMIT);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    idle(4);
    expect_now("R1 during reset");
    rst = 1'b0;
    idle(6);
    expect_now("R1 after reset");

    // R8 and R3: eight bits across the chain, first four go to device 2
    pat = 8'b1100_0101;
    for (int i = 7; i >= 0; i--) begin
      shift_bit(pat[i]);
      expect_now("R2 R4 shift, drive unchanged");
    end
    strobe_latch();
    expect_now("R3 R8 chain latch");
    if (drv1 !== 4'b0101 || drv2 !== 4'b1100) begin
      errors++;
      $display("FAIL R3 channel order: got drv1=%b drv2=%b expected drv1=0101 drv2=1100", drv1, drv2);
    end
    checks++;

    // R6
    en_n = 1'b1;
    idle(6);
    expect_now("R6 enable high forces off");
    en_n = 1'b0;
    idle(6);
    expect_now("R6 enable low restores word");

    // R5: fault load and readback through the chain
    fault1 = 4'b1001;
    fault2 = 4'b0110;
    idle(4);
    load_faults();
    expect_now("R5 fault load");
    for (int i = 0; i < 8; i++) begin
      shift_bit(1'b0);
      expect_now("R5 fault readback");
    end
    strobe_latch();
    expect_now("R4 latch after readback");

    // R2: new word, then clocks under latch high must not shift
    pat = 8'b0011_1010;
    for (int i = 7; i >= 0; i--) shift_bit(pat[i]);
    expect_now("R2 second pattern tail");
    fault1 = 4'b0111;
    fault2 = 4'b1000;
    idle(4);
    latch  = 1'b1;
    m_out1 = m_sr1;
    m_out2 = m_sr2;
    idle(6);
    for (int i = 0; i < 3; i++) begin
      din  = ~din;
      idle(3);
      sclk = 1'b1;
      serial_edge();
      idle(5);
      sclk = 1'b0;
      idle(4);
      expect_now("R5 no shift while latch high");
    end
    latch = 1'b0;
    idle(4);
    expect_now("R5 latch released");

    // R7: latch and serial clock rise together
    pat = 8'b1110_0001;
    for (int i = 7; i >= 0; i--) shift_bit(pat[i]);
    fault1 = 4'b1010;
    fault2 = 4'b0101;
    idle(4);
    latch  = 1'b1;
    sclk   = 1'b1;
    m_out1 = m_sr1;
    m_out2 = m_sr2;
    m_sr1  = fault1;
    m_sr2  = fault2;
    idle(8);
    sclk  = 1'b0;
    latch = 1'b0;
    idle(4);
    expect_now("R7 simultaneous latch and clock");

    // R1: reset in the middle of operation
    rst = 1'b1;
    idle(3);
    m_sr1 = '0; m_sr2 = '0; m_out1 = '0; m_out2 = '0;
    expect_now("R1 mid-run reset");
    rst = 1'b0;
    idle(6);
    expect_now("R1 released after mid-run reset");

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule